// File: doc/BRIEF.md
# Key-Locked Reset Watchdog

This block is a countdown watchdog that can pull the system into reset. Software sees a small 16-bit register window. The 32-bit timeout is written as two 16-bit halves. A control register arms the counter. A lock register guards every writable register except itself. After reset the block is locked. Software writes the unlock key, programs the timeout and control bits, and then writes any other value to the lock register to lock it again.

The counter does not run on a separate clock. It advances on single-cycle strobes of `tick_i`, which the surrounding logic raises at 32.768 kHz. A timeout of 50 ms is therefore a load value of 1638. When the new-load control bit is set, the counter copies the programmed timeout on the next strobe. After that it counts down on each strobe while run is set. Once it reaches zero, the next strobe reloads the timeout. If reset enable is set, that strobe also drives the reset output high for a fixed number of strobes, and the count is held during that time.

Top module: `guard_wdt`

## Requirements
- R1: After reset the block is locked, all registers and the count read zero, and `wdt_rst_o` is low.
- R2: Writing 0xE551 to the lock register (offset 0x20) unlocks the block. Bit 0 of the lock register reads 1 while unlocked.
- R3: Writing any other value to the lock register, for example 0x1AAE, locks the block, and bit 0 then reads 0.
- R4: While locked, writes to the timeout halves and the control register leave them unchanged, and the counter keeps running.
- R5: Reads return register contents whether the block is locked or unlocked.
- R6: Control bit 2 (new load) makes the next strobe copy {high half, low half} into the counter. The bit then reads 0.
- R7: While control bit 1 (run) is set, each strobe lowers the count by one, with borrow from the low half into the high half.
- R8: Without a strobe the count does not change.
- R9: While run is clear, strobes leave the count frozen.
- R10: A running strobe at count zero reloads the timeout. If control bit 3 (reset enable) is set, `wdt_rst_o` is then high for exactly RST_TICKS strobes, with the count held, and counting resumes afterwards.
- R11: Expiry with reset enable clear reloads the timeout and leaves `wdt_rst_o` low.
- R12: Register map by byte offset: low half 0x00, high half 0x04, control 0x08, count low 0x0C (read only), count high 0x10 (read only), lock 0x20. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle strobe at the 32.768 kHz timebase |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | HALF_W | Write data |
| bus_rdata_o | output | HALF_W | Read data, combinational from the offset |
| wdt_rst_o | output | 1 | Reset request output |

## Verification
A register write takes effect at the clock edge on which it is presented. Read data is combinational, so the bench samples it on the next falling edge. Counter, new-load and reset-output changes appear after the edge on which `tick_i` is high. The bench raises a strobe for one full cycle and samples one falling edge later, so its expected count equals the number of strobes given. For expiry, the bench counts strobes exactly: one for the load, L to reach zero, one that starts the pulse, then RST_TICKS until release. It checks the output and the count just before and just after each of these boundaries.

// File: rtl/guard_wdt_pkg.sv
package guard_wdt_pkg;
  // byte offsets of the register window
  localparam logic [7:0] OFF_LOAD_LO = 8'h00;
  localparam logic [7:0] OFF_LOAD_HI = 8'h04;
  localparam logic [7:0] OFF_CTRL    = 8'h08;
  localparam logic [7:0] OFF_CNT_LO  = 8'h0C;
  localparam logic [7:0] OFF_CNT_HI  = 8'h10;
  localparam logic [7:0] OFF_LOCK    = 8'h20;

  // control register bit positions
  localparam int CTRL_RUN_BIT = 1;
  localparam int CTRL_NEW_BIT = 2;
  localparam int CTRL_RST_BIT = 3;

  typedef struct packed {
    logic rst_en;
    logic new_load;
    logic run;
  } wdt_ctrl_t;
endpackage

// File: rtl/guard_wdt_regfile.sv
module guard_wdt_regfile
  import guard_wdt_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 6,
  parameter logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              load_take_i,
  output logic [CNT_W-1:0]  load_val_o,
  output wdt_ctrl_t         ctrl_o
);

  logic              unlocked_q, unlocked_d;
  logic [HALF_W-1:0] lo_q, lo_d, hi_q, hi_d;
  wdt_ctrl_t         ctrl_q, ctrl_d;
  logic              sel_lo, sel_hi, sel_ctrl, sel_lock, sel_clo, sel_chi;
  logic              prot_wr;

  assign sel_lo   = (addr_i == ADDR_W'(OFF_LOAD_LO));
  assign sel_hi   = (addr_i == ADDR_W'(OFF_LOAD_HI));
  assign sel_ctrl = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_clo  = (addr_i == ADDR_W'(OFF_CNT_LO));
  assign sel_chi  = (addr_i == ADDR_W'(OFF_CNT_HI));
  assign sel_lock = (addr_i == ADDR_W'(OFF_LOCK));
  assign prot_wr  = we_i && unlocked_q;

  // next state
  always_comb begin
    unlocked_d = unlocked_q;
    lo_d       = lo_q;
    hi_d       = hi_q;
    ctrl_d     = ctrl_q;
    if (load_take_i) ctrl_d.new_load = 1'b0;
    if (we_i && sel_lock) unlocked_d = (wdata_i == UNLOCK_KEY);
    if (prot_wr && sel_lo) lo_d = wdata_i;
    if (prot_wr && sel_hi) hi_d = wdata_i;
    if (prot_wr && sel_ctrl) begin
      ctrl_d.run      = wdata_i[CTRL_RUN_BIT];
      ctrl_d.new_load = wdata_i[CTRL_NEW_BIT];
      ctrl_d.rst_en   = wdata_i[CTRL_RST_BIT];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      lo_q       <= '0;
      hi_q       <= '0;
      ctrl_q     <= '0;
    end else begin
      unlocked_q <= unlocked_d;
      lo_q       <= lo_d;
      hi_q       <= hi_d;
      ctrl_q     <= ctrl_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (sel_lo)  rdata_o = lo_q;
    if (sel_hi)  rdata_o = hi_q;
    if (sel_clo) rdata_o = count_i[HALF_W-1:0];
    if (sel_chi) rdata_o = count_i[CNT_W-1:HALF_W];
    if (sel_ctrl) begin
      rdata_o[CTRL_RUN_BIT] = ctrl_q.run;
      rdata_o[CTRL_NEW_BIT] = ctrl_q.new_load;
      rdata_o[CTRL_RST_BIT] = ctrl_q.rst_en;
    end
    if (sel_lock) rdata_o[0] = unlocked_q;
  end

  assign load_val_o = {hi_q, lo_q};
  assign ctrl_o     = ctrl_q;

  // R4
  locked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |=> ($stable(lo_q) && $stable(hi_q)));
  // R4
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |=> ($stable(ctrl_q.run) && $stable(ctrl_q.rst_en)));
  // R2
  key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_lock && wdata_i == UNLOCK_KEY) |=> unlocked_q);
  // R3
  key_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_lock && wdata_i != UNLOCK_KEY) |=> !unlocked_q);
  // R6
  new_load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_take_i && !(prot_wr && sel_ctrl)) |=> !ctrl_q.new_load);

endmodule

// File: rtl/guard_wdt_counter.sv
module guard_wdt_counter
  import guard_wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  wdt_ctrl_t        ctrl_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             pulsing_i,
  output logic [CNT_W-1:0] count_o,
  output logic             load_take_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] count_q, count_d;
  logic             step_en;

  assign load_take_o = tick_i && ctrl_i.new_load;
  assign step_en     = tick_i && ctrl_i.run && !ctrl_i.new_load && !pulsing_i;
  assign expire_o    = step_en && (count_q == '0);

  // next state
  always_comb begin
    count_d = count_q;
    if (load_take_o || expire_o) count_d = load_val_i;
    else if (step_en)            count_d = count_q - CNT_W'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;

  // R6
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_take_o |=> (count_q == $past(load_val_i)));
  // R7
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && ctrl_i.run && !ctrl_i.new_load && !pulsing_i && count_q != '0)
      |=> (count_q == $past(count_q) - CNT_W'(1)));
  // R8
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count_q));
  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.run && !ctrl_i.new_load) |=> $stable(count_q));
  // R10
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulsing_i && !ctrl_i.new_load) |=> $stable(count_q));

endmodule

// File: rtl/guard_wdt_pulse.sv
module guard_wdt_pulse #(
  parameter int RST_TICKS = 4,
  localparam int PW = $clog2(RST_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic expire_i,
  input  logic rst_en_i,
  output logic pulsing_o,
  output logic rst_o
);

  logic [PW-1:0] left_q, left_d;
  logic          start;

  assign start = expire_i && rst_en_i;

  // next state
  always_comb begin
    left_d = left_q;
    if (start)                         left_d = PW'(RST_TICKS);
    else if (tick_i && left_q != '0)   left_d = left_q - PW'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulsing_o = (left_q != '0);
  assign rst_o     = pulsing_o;

  // R10
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= PW'(RST_TICKS));
  // R10
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(expire_i && rst_en_i));
  // R11
  no_pulse_wo_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && !rst_en_i && !rst_o) |=> !rst_o);

endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
  import guard_wdt_pkg::*;
#(
  parameter int HALF_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int RST_TICKS = 4,
  parameter logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [HALF_W-1:0] bus_wdata_i,
  output logic [HALF_W-1:0] bus_rdata_o,
  output logic              wdt_rst_o
);

  localparam int CNT_W = 2 * HALF_W;

  logic [1:0]       rsync_q;
  logic             core_rst_n;
  logic [CNT_W-1:0] count, load_val;
  logic             load_take, expire, pulsing;
  wdt_ctrl_t        ctrl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  guard_wdt_regfile #(
    .HALF_W(HALF_W), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_regs (
    .clk(clk), .rst_n(core_rst_n), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .count_i(count),
    .load_take_i(load_take), .load_val_o(load_val), .ctrl_o(ctrl)
  );

  guard_wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(core_rst_n), .tick_i(tick_i), .ctrl_i(ctrl),
    .load_val_i(load_val), .pulsing_i(pulsing), .count_o(count),
    .load_take_o(load_take), .expire_o(expire)
  );

  guard_wdt_pulse #(.RST_TICKS(RST_TICKS)) u_pulse (
    .clk(clk), .rst_n(core_rst_n), .tick_i(tick_i), .expire_i(expire),
    .rst_en_i(ctrl.rst_en), .pulsing_o(pulsing), .rst_o(wdt_rst_o)
  );

endmodule

// File: tb/guard_wdt_bench.sv
module guard_wdt_bench;
  localparam int RST_TICKS = 4;
  localparam logic [5:0] A_LO = 6'h00, A_HI = 6'h04, A_CTRL = 6'h08,
                         A_CLO = 6'h0C, A_CHI = 6'h10, A_LOCK = 6'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [5:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        wdt_rst_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  guard_wdt u_guard_wdt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .wdt_rst_o(wdt_rst_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic rd_count(output logic [31:0] c);
    logic [15:0] l, h;
    rd(A_CLO, l);
    rd(A_CHI, h);
    c = {h, l};
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  // expected count after a load of L followed by n running strobes
  function automatic logic [31:0] exp_count(input logic [31:0] l, input int n);
    return l - 32'(n);
  endfunction

  function automatic logic [15:0] ctrl_word(input bit run, input bit nl, input bit re);
    return 16'((int'(re) << 3) | (int'(nl) << 2) | (int'(run) << 1));
  endfunction

  initial begin
    logic [15:0] d;
    logic [31:0] c, l;
    int n;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_LOCK, d); check(d == 16'h0, "R1 lock", d, 0);
    rd(A_CTRL, d); check(d == 16'h0, "R1 ctrl", d, 0);
    rd_count(c);   check(c == 0, "R1 count", c, 0);
    check(wdt_rst_o == 1'b0, "R1 rst", wdt_rst_o, 0);

    // R4 / R5 locked writes ignored, reads work
    wr(A_LO, 16'h1234); rd(A_LO, d); check(d == 16'h0, "R4 lo locked", d, 0);
    wr(A_CTRL, 16'h000E); rd(A_CTRL, d); check(d == 16'h0, "R5 ctrl read locked", d, 0);

    // R2 unlock, R12 map
    wr(A_LOCK, 16'hE551); rd(A_LOCK, d); check(d == 16'h1, "R2 unlocked", d, 1);
    wr(A_LO, 16'd1638); wr(A_HI, 16'h0000);
    rd(A_LO, d); check(d == 16'd1638, "R12 lo offset", d, 1638);
    rd(6'h18, d); check(d == 16'h0, "R12 unmapped", d, 0);

    // R3 relock with complement, R4 write ignored
    wr(A_LOCK, 16'h1AAE); rd(A_LOCK, d); check(d == 16'h0, "R3 relocked", d, 0);
    wr(A_LO, 16'd5); rd(A_LO, d); check(d == 16'd1638, "R4 lo kept", d, 1638);

    // R6 new load copies {hi,lo}, bit clears
    wr(A_LOCK, 16'hE551);
    wr(A_HI, 16'h0001); wr(A_LO, 16'h0002);
    wr(A_CTRL, ctrl_word(0, 1, 0));
    rd(A_CTRL, d); check(d == 16'h0004, "R6 new bit set", d, 4);
    ticks(1);
    rd_count(c); check(c == 32'h0001_0002, "R6 loaded", c, 32'h10002);
    rd(A_CTRL, d); check(d == 16'h0, "R6 new bit cleared", d, 0);
    ticks(3);
    rd_count(c); check(c == 32'h0001_0002, "R9 frozen idle", c, 32'h10002);

    // R7 random loads and step counts; R8 no strobe; R4 locked during run
    for (int i = 0; i < 20; i++) begin
      l = 32'($urandom_range(3, 60));
      n = $urandom_range(0, int'(l) - 1);
      wr(A_HI, 16'h0); wr(A_LO, l[15:0]);
      wr(A_CTRL, ctrl_word(1, 1, 0));
      ticks(1 + n);
      rd_count(c); check(c == exp_count(l, n), "R7 random count", c, exp_count(l, n));
      repeat ($urandom_range(1, 5)) @(negedge clk);
      rd_count(c); check(c == exp_count(l, n), "R8 no strobe", c, exp_count(l, n));
      if (i % 4 == 0) begin
        wr(A_LOCK, 16'h0000);
        wr(A_CTRL, 16'h0000);
        ticks(1);
        rd_count(c); check(c == exp_count(l, n + 1), "R4 ctrl locked", c, exp_count(l, n + 1));
        wr(A_LOCK, 16'hE551);
      end
    end

    // R9 freeze by clearing run
    wr(A_LO, 16'd20); wr(A_CTRL, ctrl_word(1, 1, 0)); ticks(4);
    wr(A_CTRL, ctrl_word(0, 0, 0)); ticks(5);
    rd_count(c); check(c == 32'd17, "R9 freeze", c, 17);

    // R7 borrow across halves
    wr(A_HI, 16'h0001); wr(A_LO, 16'h0000);
    wr(A_CTRL, ctrl_word(1, 1, 0)); ticks(2);
    rd_count(c); check(c == 32'h0000_FFFF, "R7 borrow", c, 32'hFFFF);

    // R10 expiry with reset enable
    wr(A_HI, 16'h0); wr(A_LO, 16'd3);
    wr(A_CTRL, ctrl_word(1, 1, 1)); ticks(1 + 3);
    rd_count(c); check(c == 0, "R10 at zero", c, 0);
    check(wdt_rst_o == 1'b0, "R10 not early", wdt_rst_o, 0);
    ticks(1);
    check(wdt_rst_o == 1'b1, "R10 pulse start", wdt_rst_o, 1);
    rd_count(c); check(c == 32'd3, "R10 reloaded", c, 3);
    ticks(RST_TICKS - 1);
    check(wdt_rst_o == 1'b1, "R10 pulse last", wdt_rst_o, 1);
    rd_count(c); check(c == 32'd3, "R10 held", c, 3);
    ticks(1);
    check(wdt_rst_o == 1'b0, "R10 pulse end", wdt_rst_o, 0);
    ticks(1);
    rd_count(c); check(c == 32'd2, "R10 resumes", c, 2);

    // R11 expiry without reset enable
    wr(A_LO, 16'd2); wr(A_CTRL, ctrl_word(1, 1, 0)); ticks(1 + 2 + 1);
    check(wdt_rst_o == 1'b0, "R11 no pulse", wdt_rst_o, 0);
    rd_count(c); check(c == 32'd2, "R11 reloaded", c, 2);
    ticks(1);
    check(wdt_rst_o == 1'b0, "R11 still low", wdt_rst_o, 0);
    rd_count(c); check(c == 32'd1, "R11 counting", c, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule